// File: doc/BRIEF.md
# Three-Mode Power State Controller

This block decides which internal clock domains of a device receive clock pulses, and whether the crystal oscillator runs. It manages three domains: execution, bus and peripherals. It supports three states: full operation, a light sleep, and a deep sleep. In light sleep, the execution and bus domains stop and the peripherals keep running. In deep sleep, every domain stops and the oscillator is switched off. The block drives only enable signals. The gating cells, the oscillator and the supply control sit outside it.

Software chooses a sleep state by writing a two-bit mode field and then raising the halt strobe. The field clears itself back to the full-operation code when the sleep is entered, so the next halt does not sleep again by accident. An unmasked interrupt or the external wake input ends light sleep. Only the external wake input ends deep sleep. Leaving deep sleep first restarts the oscillator. It then waits a programmable number of cycles before the gated clocks are released.

Each clock enable is captured on the falling edge of the root clock, so it changes only while the clock is low. No gated clock can produce a shortened pulse. Nothing in the block is reset when a sleep state is entered or left.

Top module: `pm_ctrl`

## Requirements
- R1: After reset, all three clock enables and the oscillator enable are 1, the status reads 2'b00 and the mode field reads 2'b00.
- R2: A halt while the mode field is 2'b01 enters light sleep. The status reads 2'b01, the execution and bus enables are 0, and the peripheral and oscillator enables stay 1.
- R3: A halt while the mode field is 2'b10 enters deep sleep. The status reads 2'b10 and all three clock enables and the oscillator enable are 0.
- R4: A halt while the mode field is 2'b00 leaves the state and all enables unchanged.
- R5: The mode field takes a write of 2'b00, 2'b01 or 2'b10. A write of 2'b11 leaves the field at its previous value.
- R6: Entering either sleep state returns the mode field to 2'b00 in the same clock edge. The field is otherwise kept across sleep and wake.
- R7: In light sleep, any interrupt line whose mask bit is 0, or the external wake input, returns the block to full operation on the next edge. An interrupt line whose mask bit is 1 has no effect.
- R8: In deep sleep, interrupts have no effect. The external wake input moves the status to 2'b11 and enables the oscillator at once. The clock enables stay 0 for `settle_len`+1 cycles in total, and the block then returns to full operation.
- R9: Each clock enable changes only while the root clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Root clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Mode field write strobe |
| wr_data | input | 2 | Mode field write value |
| halt | input | 1 | Halt strobe that commits the selected mode |
| irq | input | IRQ_N | Interrupt request lines |
| irq_mask | input | IRQ_N | Per-line mask, 1 blocks the line from waking |
| wake_pd | input | 1 | External wake, ends either sleep state |
| settle_len | input | SETTLE_W | Oscillator settle cycles after deep sleep |
| exe_clk_en | output | 1 | Execution domain clock enable |
| bus_clk_en | output | 1 | Bus domain clock enable |
| per_clk_en | output | 1 | Peripheral domain clock enable |
| osc_en | output | 1 | Crystal oscillator enable |
| mode_stat | output | 2 | Current state: 00 run, 01 light, 10 deep, 11 settling |
| mode_req | output | 2 | Current mode field value |

## Verification
The assertions take several things for granted about the inputs:
- `wr_en` and `halt` are never raised in the same cycle.
- `wake_pd` is not raised together with `halt`.
- `settle_len` stays steady while the block is settling.
- All inputs are synchronous to the root clock.

The stimulus keeps to these rules. It raises each strobe alone for a single cycle, sets `settle_len` before it raises the wake input, and drives every input 1 ns before a rising edge. It then sweeps every interrupt line against every mask pattern and every settle length from 0 to 9.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PM_RUN    = 2'b00,
    PM_LIGHT  = 2'b01,
    PM_DEEP   = 2'b10,
    PM_SETTLE = 2'b11
  } pm_state_e;

  localparam logic [1:0] FIELD_RUN   = 2'b00;
  localparam logic [1:0] FIELD_LIGHT = 2'b01;
  localparam logic [1:0] FIELD_DEEP  = 2'b10;
  localparam logic [1:0] FIELD_BAD   = 2'b11;

  localparam int DOM_EXE = 0;
  localparam int DOM_BUS = 1;
  localparam int DOM_PER = 2;
  localparam int DOM_N   = 3;
endpackage

// File: rtl/pm_mode_field.sv
module pm_mode_field
  import pm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  input  logic       enter,
  output logic [1:0] field
);
  logic [1:0] field_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= FIELD_RUN;
    end else if (wr_en) begin
      if (wr_data != FIELD_BAD) field_q <= wr_data;
    end else if (enter) begin
      field_q <= FIELD_RUN;
    end
  end

  assign field = field_q;
endmodule

// File: rtl/pm_wake_sel.sv
module pm_wake_sel #(
  parameter int IRQ_N = 4
) (
  input  logic [IRQ_N-1:0] irq,
  input  logic [IRQ_N-1:0] irq_mask,
  input  logic             wake_pd,
  output logic             wake_light,
  output logic             wake_deep
);
  logic [IRQ_N-1:0] live;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_line
    assign live[g] = irq[g] & ~irq_mask[g];
  end

  assign wake_light = (|live) | wake_pd;
  assign wake_deep  = wake_pd;
endmodule

// File: rtl/pm_seq.sv
module pm_seq
  import pm_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt,
  input  logic [1:0]          field,
  input  logic                wake_light,
  input  logic                wake_deep,
  input  logic [SETTLE_W-1:0] settle_len,
  output pm_state_e           state,
  output logic                enter
);
  pm_state_e           st_q, st_d;
  logic [SETTLE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    enter = 1'b0;
    unique case (st_q)
      PM_RUN: begin
        if (halt && field == FIELD_LIGHT) begin
          st_d  = PM_LIGHT;
          enter = 1'b1;
        end else if (halt && field == FIELD_DEEP) begin
          st_d  = PM_DEEP;
          enter = 1'b1;
        end
      end
      PM_LIGHT: begin
        if (wake_light) st_d = PM_RUN;
      end
      PM_DEEP: begin
        if (wake_deep) begin
          st_d  = PM_SETTLE;
          cnt_d = settle_len;
        end
      end
      PM_SETTLE: begin
        if (cnt_q == '0) st_d = PM_RUN;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PM_RUN;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/pm_gate_en.sv
module pm_gate_en #(
  parameter int DOMAINS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DOMAINS-1:0] want,
  output logic [DOMAINS-1:0] en
);
  for (genvar g = 0; g < DOMAINS; g++) begin : g_dom
    logic en_q;
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b1;
      else        en_q <= want[g];
    end
    assign en[g] = en_q;
  end
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
#(
  parameter int IRQ_N    = 4,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_data,
  input  logic                halt,
  input  logic [IRQ_N-1:0]    irq,
  input  logic [IRQ_N-1:0]    irq_mask,
  input  logic                wake_pd,
  input  logic [SETTLE_W-1:0] settle_len,
  output logic                exe_clk_en,
  output logic                bus_clk_en,
  output logic                per_clk_en,
  output logic                osc_en,
  output logic [1:0]          mode_stat,
  output logic [1:0]          mode_req
);
  pm_state_e        state;
  logic             enter, wake_light, wake_deep;
  logic [DOM_N-1:0] want, en;

  pm_mode_field u_field (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .enter(enter), .field(mode_req)
  );

  pm_wake_sel #(.IRQ_N(IRQ_N)) u_wake (
    .irq(irq), .irq_mask(irq_mask), .wake_pd(wake_pd),
    .wake_light(wake_light), .wake_deep(wake_deep)
  );

  pm_seq #(.SETTLE_W(SETTLE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .halt(halt), .field(mode_req),
    .wake_light(wake_light), .wake_deep(wake_deep),
    .settle_len(settle_len), .state(state), .enter(enter)
  );

  always_comb begin
    want          = '0;
    want[DOM_EXE] = (state == PM_RUN);
    want[DOM_BUS] = (state == PM_RUN);
    want[DOM_PER] = (state == PM_RUN) || (state == PM_LIGHT);
  end

  pm_gate_en #(.DOMAINS(DOM_N)) u_gate (
    .clk(clk), .rst_n(rst_n), .want(want), .en(en)
  );

  assign exe_clk_en = en[DOM_EXE];
  assign bus_clk_en = en[DOM_BUS];
  assign per_clk_en = en[DOM_PER];
  assign osc_en     = (state != PM_DEEP);
  assign mode_stat  = state;
endmodule

// File: rtl/pm_ctrl_chk.sv
module pm_ctrl_chk #(
  parameter int IRQ_N = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_data,
  input logic             halt,
  input logic [IRQ_N-1:0] irq,
  input logic [IRQ_N-1:0] irq_mask,
  input logic             wake_pd,
  input logic             exe_clk_en,
  input logic             bus_clk_en,
  input logic             per_clk_en,
  input logic             osc_en,
  input logic [1:0]       mode_stat,
  input logic [1:0]       mode_req
);
  a_r2_light_gating: assert property (@(posedge clk) disable iff (!rst_n)
    mode_stat == 2'b01 |-> !exe_clk_en && !bus_clk_en && per_clk_en && osc_en);

  a_r3_deep_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    mode_stat == 2'b10 |-> !exe_clk_en && !bus_clk_en && !per_clk_en && !osc_en);

  a_r4_run_halt_noop: assert property (@(posedge clk) disable iff (!rst_n)
    mode_stat == 2'b00 && halt && mode_req == 2'b00 |=> mode_stat == 2'b00);

  a_r5_bad_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data == 2'b11 && !halt |=> $stable(mode_req));

  a_r6_field_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mode_stat == 2'b00 && halt && !wr_en && mode_req != 2'b00 && mode_req != 2'b11
    |=> mode_req == 2'b00);

  a_r7_light_wake: assert property (@(posedge clk) disable iff (!rst_n)
    mode_stat == 2'b01 && ((|(irq & ~irq_mask)) || wake_pd) |=> mode_stat == 2'b00);

  a_r8_deep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    mode_stat == 2'b10 && !wake_pd |=> mode_stat == 2'b10);

  a_r8_settle_osc_first: assert property (@(posedge clk) disable iff (!rst_n)
    mode_stat == 2'b11 |-> osc_en && !exe_clk_en && !bus_clk_en && !per_clk_en);

  always @(exe_clk_en or bus_clk_en or per_clk_en) begin
    if (rst_n === 1'b1) a_r9_change_low: assert (clk !== 1'b1);
  end
endmodule

bind pm_ctrl pm_ctrl_chk #(.IRQ_N(IRQ_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .halt(halt),
  .irq(irq), .irq_mask(irq_mask), .wake_pd(wake_pd),
  .exe_clk_en(exe_clk_en), .bus_clk_en(bus_clk_en), .per_clk_en(per_clk_en),
  .osc_en(osc_en), .mode_stat(mode_stat), .mode_req(mode_req)
);

// File: tb/test_pm_ctrl.sv
`timescale 1ns/1ps
module test_pm_ctrl;
  localparam int IRQ_N    = 4;
  localparam int SETTLE_W = 8;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                wr_en = 1'b0;
  logic [1:0]          wr_data = '0;
  logic                halt = 1'b0;
  logic [IRQ_N-1:0]    irq = '0;
  logic [IRQ_N-1:0]    irq_mask = '0;
  logic                wake_pd = 1'b0;
  logic [SETTLE_W-1:0] settle_len = '0;
  logic                exe_clk_en, bus_clk_en, per_clk_en, osc_en;
  logic [1:0]          mode_stat, mode_req;

  int n_cmp = 0;
  int n_bad = 0;
  int n_edge_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pm_ctrl #(.IRQ_N(IRQ_N), .SETTLE_W(SETTLE_W)) i_pm_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .halt(halt),
    .irq(irq), .irq_mask(irq_mask), .wake_pd(wake_pd), .settle_len(settle_len),
    .exe_clk_en(exe_clk_en), .bus_clk_en(bus_clk_en), .per_clk_en(per_clk_en),
    .osc_en(osc_en), .mode_stat(mode_stat), .mode_req(mode_req)
  );

  // R9 monitor: any enable change seen while the root clock is high
  always @(exe_clk_en or bus_clk_en or per_clk_en)
    if (rst_n === 1'b1 && clk === 1'b1) n_edge_err++;

  // wait for a rising edge, then 4 ns so the falling-edge enables have settled
  task automatic cyc();
    @(posedge clk);
    #4;
  endtask

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // packed view {stat, exe, bus, per, osc}
  function automatic logic [5:0] view();
    return {mode_stat, exe_clk_en, bus_clk_en, per_clk_en, osc_en};
  endfunction

  task automatic write_field(logic [1:0] v);
    wr_en = 1'b1; wr_data = v; cyc(); wr_en = 1'b0;
  endtask

  task automatic do_halt();
    halt = 1'b1; cyc(); halt = 1'b0;
  endtask

  initial begin
    #50000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    chk("R1 reset state", view(), 6'b00_1111);
    chk("R1 reset field", {4'b0, mode_req}, 6'd0);
    rst_n = 1'b1;
    cyc();
    chk("R1 after release", view(), 6'b00_1111);

    // R4: halt with field at run code does nothing
    do_halt();
    chk("R4 halt on run field", view(), 6'b00_1111);

    // R5: field writes, 11 ignored
    write_field(2'b10);
    chk("R5 write 10", {4'b0, mode_req}, 6'd2);
    write_field(2'b11);
    chk("R5 write 11 ignored", {4'b0, mode_req}, 6'd2);
    write_field(2'b01);
    chk("R5 write 01", {4'b0, mode_req}, 6'd1);
    write_field(2'b11);
    chk("R5 write 11 ignored again", {4'b0, mode_req}, 6'd1);
    write_field(2'b00);
    chk("R5 write 00", {4'b0, mode_req}, 6'd0);

    // R2/R6/R7: sweep every line against every mask pattern
    for (int m = 0; m < (1 << IRQ_N); m++) begin
      for (int i = 0; i < IRQ_N; i++) begin
        write_field(2'b01);
        do_halt();
        chk("R2 light sleep", view(), 6'b01_0011);
        chk("R6 field cleared on light entry", {4'b0, mode_req}, 6'd0);
        irq_mask = m[IRQ_N-1:0];
        irq = '0; irq[i] = 1'b1;
        cyc();
        irq = '0;
        if (m[i]) begin
          chk("R7 masked line ignored", view(), 6'b01_0011);
          wake_pd = 1'b1; cyc(); wake_pd = 1'b0;
          chk("R7 wake input ends light sleep", view(), 6'b00_1111);
        end else begin
          chk("R7 unmasked line wakes", view(), 6'b00_1111);
        end
      end
    end
    irq_mask = '0;

    // R3/R6/R8: deep sleep with each settle length
    for (int L = 0; L < 10; L++) begin
      write_field(2'b10);
      do_halt();
      chk("R3 deep sleep", view(), 6'b10_0000);
      chk("R6 field cleared on deep entry", {4'b0, mode_req}, 6'd0);
      irq = '1; cyc(); irq = '0;
      chk("R8 interrupts ignored in deep", view(), 6'b10_0000);
      settle_len = SETTLE_W'(L);
      wake_pd = 1'b1; cyc(); wake_pd = 1'b0;
      chk("R8 oscillator first", view(), 6'b11_0001);
      for (int k = 0; k < L; k++) begin
        cyc();
        chk("R8 still settling", view(), 6'b11_0001);
      end
      cyc();
      chk("R8 released after settle", view(), 6'b00_1111);
    end

    // R6: field kept across a sleep when rewritten before wake path
    write_field(2'b10);
    do_halt();
    write_field(2'b01);
    chk("R6 field kept in deep sleep", {4'b0, mode_req}, 6'd1);
    settle_len = '0;
    wake_pd = 1'b1; cyc(); wake_pd = 1'b0;
    cyc();
    chk("R6 field kept after wake", {4'b0, mode_req}, 6'd1);
    write_field(2'b00);

    chk("R9 enables change only while clock low", 6'(n_edge_err), 6'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule